// File: doc/BRIEF.md
# Pipelined Bitonic Key Sorter

This block orders a set of eight unsigned keys, all of one parameterised width, with a fixed bitonic comparison network. The network is built bottom-up. First, pairs are merged into runs of two. Those runs are merged into runs of four, and a final merge produces one run of eight. In total there are six comparator levels with four compare-and-exchange cells on each level. Within the first two stages, adjacent runs are ordered in opposite senses. This makes each pair of runs a rising-then-falling sequence, which the next merge can finish.

The six levels are split by pipeline registers into three segments of two levels each. The clock period is therefore limited by the deepest two-level segment rather than by the whole network. A new key set can enter on every clock. A valid flag and a per-set direction bit travel with the data, so each set comes out fully ordered exactly three cycles after it was presented. The direction bit selects smallest-first or largest-first for that set.

Top module: `bitonic_sort8_pipe`

## Requirements
- R1: When a set is presented with `in_desc` = 0, the matching output set has `key_out` lanes non-decreasing from lane 0 (bits [KEY_W-1:0]) to lane 7.
- R2: When a set is presented with `in_desc` = 1, the matching output set has `key_out` lanes non-increasing from lane 0 to lane 7.
- R3: Each output set is a permutation of its input set: duplicate and extreme key values (all zeros, all ones) are all preserved.
- R4: `out_valid` rises exactly 3 clock cycles after the cycle in which `in_valid` was high, and the set appears on `key_out` in that same cycle.
- R5: A new set is accepted on every cycle with `in_valid` high, including unbroken back-to-back runs, and no set is lost or merged with a neighbour.
- R6: `out_desc` equals the `in_desc` value presented with the set now on `key_out`, and direction may change from one set to the next.
- R7: A synchronous `rst` clears every in-flight valid flag: in the cycle after a clock edge with `rst` high, `out_valid` is 0, and a set presented together with `rst` never emerges.
- R8: A cycle with `in_valid` low produces a cycle with `out_valid` low 3 cycles later, whatever `key_in` held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input key set is valid this cycle |
| in_desc | input | 1 | 0: smallest key to lane 0; 1: largest key to lane 0 |
| key_in | input | LANES*KEY_W | Input keys, lane i at bits [i*KEY_W +: KEY_W] |
| out_valid | output | 1 | Output key set is valid this cycle |
| out_desc | output | 1 | Direction bit that travelled with the output set |
| key_out | output | LANES*KEY_W | Ordered keys, lane i at bits [i*KEY_W +: KEY_W] |

## Verification
A synchronous reset can arrive while sets are still in flight and while a new set is being presented on the same edge. The bench provokes this by streaming sets back-to-back and then raising `rst` together with `in_valid` on one cycle. It judges the result by requiring that none of the flushed sets and not the colliding set ever show `out_valid`, and that the stream after release is ordered and timed correctly. A second collision is also exercised: an ascending set and a descending set occupy neighbouring pipeline segments. Consecutive sets with alternating `in_desc` must each leave in their own order with their own `out_desc`.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

   // Stage number (1-based) of a flat comparator level index.
   function automatic int level_stage(input int lvl);
      int s;
      int rem;
      s   = 1;
      rem = lvl;
      for (int k = 0; k < 64; k++) begin
         if (rem >= s) begin
            rem = rem - s;
            s   = s + 1;
         end
      end
      return s;
   endfunction

   // Lane distance between the two keys a cell compares on this level.
   function automatic int level_dist(input int lvl);
      int s;
      int rem;
      s   = 1;
      rem = lvl;
      for (int k = 0; k < 64; k++) begin
         if (rem >= s) begin
            rem = rem - s;
            s   = s + 1;
         end
      end
      return 1 << (s - 1 - rem);
   endfunction

   // Width of the run being merged on this level; lane bit selects sense.
   function automatic int level_block(input int lvl);
      return 1 << level_stage(lvl);
   endfunction

   function automatic int level_total(input int lanes_log2);
      return lanes_log2 * (lanes_log2 + 1) / 2;
   endfunction

endpackage

// File: rtl/bsort_cas.sv
module bsort_cas #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         up,
   output logic [W-1:0] lo,
   output logic [W-1:0] hi
);
   logic swap;

   always_comb begin
      swap = up ? (a > b) : (a < b);
      lo   = swap ? b : a;
      hi   = swap ? a : b;
   end
endmodule

// File: rtl/bsort_level.sv
module bsort_level #(
   parameter int LANES = 8,
   parameter int W     = 16,
   parameter int DIST  = 1,
   parameter int BLOCK = 2
) (
   input  logic                 desc,
   input  logic [LANES*W-1:0]   d_in,
   output logic [LANES*W-1:0]   d_out
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if ((i & DIST) == 0) begin : g_cell
         localparam bit RISING = ((i & BLOCK) == 0);
         bsort_cas #(.W(W)) u_cas (
            .a  (d_in[i*W +: W]),
            .b  (d_in[(i+DIST)*W +: W]),
            .up (RISING ^ desc),
            .lo (d_out[i*W +: W]),
            .hi (d_out[(i+DIST)*W +: W])
         );
      end
   end
endmodule

// File: rtl/bsort_segment.sv
module bsort_segment #(
   parameter int LANES = 8,
   parameter int W     = 16,
   parameter int FIRST = 0,
   parameter int NLVL  = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 v_in,
   input  logic                 dir_in,
   input  logic [LANES*W-1:0]   d_in,
   output logic                 v_out,
   output logic                 dir_out,
   output logic [LANES*W-1:0]   d_out
);
   logic [LANES*W-1:0] chain [0:NLVL];

   assign chain[0] = d_in;

   for (genvar j = 0; j < NLVL; j++) begin : g_lvl
      bsort_level #(
         .LANES (LANES),
         .W     (W),
         .DIST  (bsort_pkg::level_dist(FIRST + j)),
         .BLOCK (bsort_pkg::level_block(FIRST + j))
      ) u_lvl (
         .desc  (dir_in),
         .d_in  (chain[j]),
         .d_out (chain[j+1])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) v_out <= 1'b0;
      else     v_out <= v_in;
   end

   always_ff @(posedge clk) begin
      if (v_in) begin
         d_out   <= chain[NLVL];
         dir_out <= dir_in;
      end
   end
endmodule

// File: rtl/bitonic_sort8_pipe.sv
module bitonic_sort8_pipe #(
   parameter int LANES       = 8,
   parameter int KEY_W       = 16,
   parameter int LVL_PER_SEG = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic                     in_desc,
   input  logic [LANES*KEY_W-1:0]   key_in,
   output logic                     out_valid,
   output logic                     out_desc,
   output logic [LANES*KEY_W-1:0]   key_out
);
   localparam int LOG2L   = $clog2(LANES);
   localparam int NLVL    = bsort_pkg::level_total(LOG2L);
   localparam int NSEG    = (NLVL + LVL_PER_SEG - 1) / LVL_PER_SEG;
   localparam int LATENCY = NSEG;

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two, at least 2");
   end
   if (KEY_W < 1) begin : g_bad_width
      $error("KEY_W must be at least 1");
   end
   if (LVL_PER_SEG < 1) begin : g_bad_split
      $error("LVL_PER_SEG must be at least 1");
   end

   logic                   v_s   [0:NSEG];
   logic                   dir_s [0:NSEG];
   logic [LANES*KEY_W-1:0] dat_s [0:NSEG];

   assign v_s[0]   = in_valid;
   assign dir_s[0] = in_desc;
   assign dat_s[0] = key_in;

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      localparam int FIRST = g * LVL_PER_SEG;
      localparam int CNT   = (NLVL - FIRST < LVL_PER_SEG) ? (NLVL - FIRST) : LVL_PER_SEG;
      bsort_segment #(
         .LANES (LANES),
         .W     (KEY_W),
         .FIRST (FIRST),
         .NLVL  (CNT)
      ) u_seg (
         .clk     (clk),
         .rst     (rst),
         .v_in    (v_s[g]),
         .dir_in  (dir_s[g]),
         .d_in    (dat_s[g]),
         .v_out   (v_s[g+1]),
         .dir_out (dir_s[g+1]),
         .d_out   (dat_s[g+1])
      );
   end

   assign out_valid = v_s[NSEG];
   assign out_desc  = dir_s[NSEG];
   assign key_out   = dat_s[NSEG];
endmodule

// File: rtl/bsort_chk.sv
module bsort_chk #(
   parameter int LANES   = 8,
   parameter int KEY_W   = 16,
   parameter int LATENCY = 3
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    in_valid,
   input logic                    in_desc,
   input logic [LANES*KEY_W-1:0]  key_in,
   input logic                    out_valid,
   input logic                    out_desc,
   input logic [LANES*KEY_W-1:0]  key_out
);
   localparam int SUM_W = KEY_W + $clog2(LANES) + 1;

   function automatic logic [SUM_W-1:0] key_sum(input logic [LANES*KEY_W-1:0] v);
      logic [SUM_W-1:0] acc;
      acc = '0;
      for (int i = 0; i < LANES; i++) acc = acc + SUM_W'(v[i*KEY_W +: KEY_W]);
      return acc;
   endfunction

   function automatic logic in_order(input logic [LANES*KEY_W-1:0] v, input logic dn);
      logic ok;
      ok = 1'b1;
      for (int i = 0; i + 1 < LANES; i++) begin
         if (!dn && v[i*KEY_W +: KEY_W] > v[(i+1)*KEY_W +: KEY_W]) ok = 1'b0;
         if ( dn && v[i*KEY_W +: KEY_W] < v[(i+1)*KEY_W +: KEY_W]) ok = 1'b0;
      end
      return ok;
   endfunction

   logic [LATENCY-1:0] vsh;
   logic [LATENCY-1:0] dsh;
   logic [SUM_W-1:0]   ssh [0:LATENCY-1];

   always_ff @(posedge clk) begin
      if (rst) vsh <= '0;
      else begin
         vsh[0] <= in_valid;
         for (int k = 1; k < LATENCY; k++) vsh[k] <= vsh[k-1];
      end
   end

   always_ff @(posedge clk) begin
      dsh[0] <= in_desc;
      ssh[0] <= key_sum(key_in);
      for (int k = 1; k < LATENCY; k++) begin
         dsh[k] <= dsh[k-1];
         ssh[k] <= ssh[k-1];
      end
   end

   p_ascending_r1: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_desc) |-> in_order(key_out, 1'b0));

   p_descending_r2: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_desc) |-> in_order(key_out, 1'b1));

   p_sum_kept_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (key_sum(key_out) == ssh[LATENCY-1]));

   p_latency_r4: assert property (@(posedge clk) disable iff (rst)
      out_valid == vsh[LATENCY-1]);

   p_dir_carried_r6: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_desc == dsh[LATENCY-1]));

   p_reset_clears_r7: assert property (@(posedge clk)
      rst |=> !out_valid);
endmodule

bind bitonic_sort8_pipe bsort_chk #(
   .LANES   (LANES),
   .KEY_W   (KEY_W),
   .LATENCY (LATENCY)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_desc   (in_desc),
   .key_in    (key_in),
   .out_valid (out_valid),
   .out_desc  (out_desc),
   .key_out   (key_out)
);

// File: tb/sim_bitonic_sort8_pipe.sv
module sim_bitonic_sort8_pipe;
   localparam int CLK_PERIOD = 10;
   localparam int N   = 8;
   localparam int W   = 8;
   localparam int LAT = 3;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           in_valid = 1'b0;
   logic           in_desc = 1'b0;
   logic [N*W-1:0] key_in = '0;
   logic           out_valid;
   logic           out_desc;
   logic [N*W-1:0] key_out;

   bitonic_sort8_pipe #(.LANES(N), .KEY_W(W), .LVL_PER_SEG(2)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_desc(in_desc),
      .key_in(key_in), .out_valid(out_valid), .out_desc(out_desc), .key_out(key_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      logic [N*W-1:0] keys;
      logic           desc;
      int             due;
      string          tag;
   } exp_t;

   exp_t  sb[$];
   int    cyc = 0;
   int    checks = 0;
   int    failures = 0;
   bit    armed = 1'b0;
   bit    done = 1'b0;
   string idle_tag = "R8";

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v, input logic dn);
      int a [N];
      int t;
      logic [N*W-1:0] r;
      for (int i = 0; i < N; i++) a[i] = int'(v[i*W +: W]);
      for (int p = 0; p < N; p++)
         for (int i = 0; i + 1 < N; i++)
            if ((!dn && a[i] > a[i+1]) || (dn && a[i] < a[i+1])) begin
               t = a[i]; a[i] = a[i+1]; a[i+1] = t;
            end
      for (int i = 0; i < N; i++) r[i*W +: W] = W'(a[i]);
      return r;
   endfunction

   function automatic logic [N*W-1:0] rand_keys();
      logic [N*W-1:0] r;
      for (int i = 0; i < N; i++) r[i*W +: W] = W'($urandom);
      return r;
   endfunction

   function automatic logic [N*W-1:0] pack8(input int k0, k1, k2, k3, k4, k5, k6, k7);
      return {W'(k7), W'(k6), W'(k5), W'(k4), W'(k3), W'(k2), W'(k1), W'(k0)};
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Driver: presents one set and queues its expected result.
   task automatic send(input logic [N*W-1:0] k, input logic dn, input string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      in_desc  = dn;
      key_in   = k;
      e.keys = ref_sort(k, dn);
      e.desc = dn;
      e.due  = cyc + LAT;
      e.tag  = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_desc  = 1'($urandom);
         key_in   = rand_keys();
      end
   endtask

   // Monitor: pops expected sets when due, otherwise demands a quiet output.
   always @(negedge clk) begin
      if (armed && !done) begin
         if (sb.size() > 0 && sb[0].due == cyc) begin
            check(out_valid === 1'b1, "R4", "out_valid missing", {63'd0, out_valid}, 64'd1);
            check(key_out === sb[0].keys, sb[0].tag, "key order", key_out, sb[0].keys);
            check(out_desc === sb[0].desc, "R6", "out_desc", {63'd0, out_desc}, {63'd0, sb[0].desc});
            void'(sb.pop_front());
         end else begin
            check(out_valid === 1'b0, idle_tag, "unexpected out_valid", {63'd0, out_valid}, 64'd0);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R7: reset state seen at the output
      check(out_valid === 1'b0, "R7", "out_valid after reset", {63'd0, out_valid}, 64'd0);
      armed = 1'b1;

      // R1 / R2: a fixed set in both senses
      send(pack8(5, 1, 4, 2, 8, 3, 7, 6), 1'b0, "R1");
      idle(4);
      send(pack8(5, 1, 4, 2, 8, 3, 7, 6), 1'b1, "R2");
      idle(4);

      // R3: duplicates, extremes, presorted and reversed sets
      send(pack8(9, 9, 9, 9, 9, 9, 9, 9), 1'b0, "R3");
      send(pack8(255, 0, 255, 0, 7, 7, 0, 255), 1'b0, "R3");
      send(pack8(255, 0, 255, 0, 7, 7, 0, 255), 1'b1, "R3");
      send(pack8(0, 1, 2, 3, 4, 5, 6, 7), 1'b0, "R3");
      send(pack8(0, 1, 2, 3, 4, 5, 6, 7), 1'b1, "R3");
      send(pack8(200, 150, 100, 50, 40, 30, 20, 10), 1'b0, "R3");
      idle(5);

      // R5 / R6: unbroken stream with alternating and random direction
      for (int i = 0; i < 40; i++) send(rand_keys(), 1'(i % 2), "R5");
      for (int i = 0; i < 40; i++) send(rand_keys(), 1'($urandom), "R6");
      idle(5);

      // R8: random gaps between sets
      for (int i = 0; i < 120; i++) begin
         if ($urandom_range(0, 2) == 0) idle(1);
         else send(rand_keys(), 1'($urandom), "R8");
      end
      idle(5);

      // R7: reset lands on a full pipeline together with a new set
      for (int i = 0; i < 4; i++) send(rand_keys(), 1'($urandom), "R7");
      @(negedge clk);
      #1;
      sb.delete();
      idle_tag = "R7";
      rst      = 1'b1;
      in_valid = 1'b1;
      key_in   = rand_keys();
      @(negedge clk);
      rst      = 1'b0;
      in_valid = 1'b0;
      idle(6);
      idle_tag = "R8";

      // recovery stream after reset
      for (int i = 0; i < 200; i++) begin
         if ($urandom_range(0, 4) == 0) idle(1);
         else send(rand_keys(), 1'($urandom), (i % 2 == 0) ? "R1" : "R2");
      end
      idle(LAT + 3);

      check(sb.size() == 0, "R4", "sets never emerged", 64'(sb.size()), 64'd0);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule